// File: doc/BRIEF.md
# Clock Stop Gating Controller

This block produces two families of divided clock outputs from one fast reference clock. The first family runs at the CPU rate and has gated CPU outputs, gated memory outputs and one free-running output of each kind. The second family runs at the PCI rate and has gated outputs and one free-running output. The PCI-rate clock is made inside the block by dividing the CPU-rate clock, so the whole block runs in one clock domain.

Each family has its own asynchronous active-low stop request. Each request passes through a two-stage synchronizer before it is used. The gate for a family changes only while that family's clock is low. As a result, an output stops in the low state and restarts with a complete high phase. Once a family is restarted, a minimum run time applies. A stop request that arrives during that time is held and takes effect when the time has passed. A per-output enable bit can hold any output low, the free-running ones included.

Top module: `ckstop_gate_top`

## Requirements
- R1: While `cpu_stop_n` is high, every enabled gated CPU and memory output toggles with the CPU-rate clock. `cpu_free_o` and `sdr_free_o` toggle whatever `cpu_stop_n` does.
- R2: A low level on `cpu_stop_n` is sampled on a CPU rising edge, counted as edge 1. Edge 2 still delivers a pulse. Edge 3 is the first edge with the gated CPU and memory outputs held at 0, so the stop latency is under 4 CPU cycles.
- R3: A high level on `cpu_stop_n` is sampled on a CPU rising edge, counted as edge 1. Edge 3 is the first edge to deliver a pulse on the gated CPU and memory outputs again.
- R4: After a restart, and after reset, the gated CPU group delivers at least CPU_MIN_RUN (100) pulses before it stops. A stop request seen earlier is held until that count is reached.
- R5: While `pci_stop_n` is low, the gated PCI outputs halt at 0 after the latency in R6. `pci_free_o` keeps toggling.
- R6: A PCI stop or release is sampled on a PCI rising edge, counted as edge 1. Edge 3 is the first edge to change: the first missing pulse on a stop, the first delivered pulse on a release. On a stop, one more full PCI pulse (edge 2) goes out after the sampling edge.
- R7: After a restart, and after reset, the gated PCI group delivers at least PCI_MIN_RUN (10) pulses before it stops. A stop request seen earlier is held until that count is reached.
- R8: A gated output rises only in the cycle in which its family clock rises, and falls only in the cycle in which that clock falls. It is never high while the family clock is low. Every high pulse is therefore full width.
- R9: An output whose enable bit is 0 is held at 0 and does not switch. This holds for the free-running outputs too. A change of enable bit takes effect at the next low phase of the family clock.
- R10: While `rst_n` is low, every output is 0.
- R11: One PCI period is 2*PCI_HALF CPU periods (4 by default). Every PCI rising edge falls in the same reference cycle as a CPU rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous stop request for the CPU family, active low |
| pci_stop_n | input | 1 | Asynchronous stop request for the PCI family, active low |
| cpu_en | input | NCPU | Enable bits of the gated CPU outputs |
| cpu_free_en | input | 1 | Enable bit of the free-running CPU output |
| sdr_en | input | NSDR | Enable bits of the gated memory outputs |
| sdr_free_en | input | 1 | Enable bit of the free-running memory output |
| pci_en | input | NPCI | Enable bits of the gated PCI outputs |
| pci_free_en | input | 1 | Enable bit of the free-running PCI output |
| cpu_clk_o | output | NCPU | Gated CPU-rate clocks |
| cpu_free_o | output | 1 | Free-running CPU-rate clock |
| sdr_clk_o | output | NSDR | Gated memory clocks at the CPU rate |
| sdr_free_o | output | 1 | Free-running memory clock |
| pci_clk_o | output | NPCI | Gated PCI-rate clocks |
| pci_free_o | output | 1 | Free-running PCI-rate clock |

## Verification
The assertions check on every cycle the following:
- that gated outputs are never high while their family clock is low;
- that gated outputs rise and fall only together with that clock;
- that gates move only in the low phase;
- that neither family stops before its minimum pulse count;
- that PCI rising edges line up with CPU rising edges.

The exact edge on which a stop or restart lands depends on the sequence of request levels across several edges, so only the bench scenarios can show it. The same holds for a request held pending through the run window and for the effect of the enable masks. The bench checks these edge by edge against a model built from the latency and run-window rules.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock stop gating controller.
// Assumes: nothing beyond a synthesizable SystemVerilog tool flow.
package ckg_pkg;

    // Run state of one clock family.
    typedef enum logic {
        GRP_HALT = 1'b0,
        GRP_RUN  = 1'b1
    } grp_state_e;

    // Width of a counter that must hold values 0 .. n-1 (at least 1 bit).
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ckg_divider.sv
`timescale 1ns/1ps
// Divides a step enable by 2*HALF into a square-wave phase.
// The rise_tick and fall_tick outputs flag the cycle at whose closing edge
// the phase goes high or low. phase_nxt is the phase value after that edge.
// Assumes: HALF >= 1 and step asserted at the rate being divided.
// After reset the phase is high, so the first tick is a falling one.
module ckg_divider #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic phase_nxt,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = ckg_pkg::cnt_width(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic          phase;
    logic [CW-1:0] cnt;
    logic          wrap;

    // Decode the end of a half period and the resulting phase.
    always_comb begin
        wrap      = step && (cnt == LAST);
        rise_tick = wrap && !phase;
        fall_tick = wrap && phase;
        phase_nxt = phase ^ wrap;
    end

    // Advance the half-period counter and the phase on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (step) begin
            cnt   <= wrap ? '0 : cnt + 1'b1;
            phase <= phase_nxt;
        end
    end
endmodule

// File: rtl/ckg_stop_ctrl.sv
`timescale 1ns/1ps
// Stop/restart control for one clock family.
// The asynchronous active-low request is synchronized by two flops that
// sample on the family's rising ticks. The gate changes only on a falling
// tick, so it never cuts or starts a high phase. After the gate opens it
// stays open for at least MIN_RUN rising ticks. A stop seen earlier
// waits until that count is reached.
// Assumes: rise_tick and fall_tick are never asserted in the same cycle.
module ckg_stop_ctrl #(
    parameter int MIN_RUN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n,
    input  logic rise_tick,
    input  logic fall_tick,
    output logic gate
);
    import ckg_pkg::*;

    localparam int RW = cnt_width(MIN_RUN + 1);
    localparam logic [RW-1:0] RUN_DONE = RW'(MIN_RUN);

    logic          sync1, sync2;
    logic [RW-1:0] run_cnt;
    grp_state_e    state;

    // Two-stage synchronizer clocked by the family's rising ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else if (rise_tick) begin
            sync1 <= stop_n;
            sync2 <= sync1;
        end
    end

    // Count pulses while running and move the gate only in the low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= GRP_RUN;
            run_cnt <= '0;
        end else begin
            if (rise_tick && state == GRP_RUN && run_cnt != RUN_DONE)
                run_cnt <= run_cnt + 1'b1;
            if (fall_tick) begin
                case (state)
                    GRP_RUN: begin
                        if (!sync2 && run_cnt == RUN_DONE) begin
                            state   <= GRP_HALT;
                            run_cnt <= '0;
                        end
                    end
                    default: begin
                        if (sync2)
                            state <= GRP_RUN;
                    end
                endcase
            end
        end
    end

    assign gate = (state == GRP_RUN);
endmodule

// File: rtl/ckg_out_bank.sv
`timescale 1ns/1ps
// A bank of N registered clock outputs that share one family phase and gate.
// Enable bits are taken in only on a falling tick, when the phase is about
// to be low, so a mask change cannot shorten a high phase.
// Assumes: gate itself changes only on a falling tick.
module ckg_out_bank #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase_nxt,
    input  logic         fall_tick,
    input  logic         gate,
    input  logic [N-1:0] en,
    output logic [N-1:0] clk_o
);
    logic [N-1:0] en_q;

    // Capture the enable mask at the start of a low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (fall_tick)
            en_q <= en;
    end

    // Register each output as phase AND gate AND its enable bit.
    for (genvar i = 0; i < N; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (!rst_n)
                clk_o[i] <= 1'b0;
            else
                clk_o[i] <= phase_nxt & gate & en_q[i];
        end
    end
endmodule

// File: rtl/ckstop_gate_top.sv
`timescale 1ns/1ps
// Clock stop gating controller, top level.
// Makes a CPU-rate clock (period 2*CPU_HALF reference cycles) and a
// PCI-rate clock (period 2*PCI_HALF CPU cycles, rising with the CPU clock).
// It gates both families under their own synchronized stop requests and
// enable masks. The free-running outputs ignore the stop requests.
// Assumes: one reference clock domain; stop requests may be asynchronous.
module ckstop_gate_top #(
    parameter int NCPU        = 3,
    parameter int NSDR        = 8,
    parameter int NPCI        = 6,
    parameter int CPU_HALF    = 2,
    parameter int PCI_HALF    = 2,
    parameter int CPU_MIN_RUN = 100,
    parameter int PCI_MIN_RUN = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic [NCPU-1:0] cpu_en,
    input  logic            cpu_free_en,
    input  logic [NSDR-1:0] sdr_en,
    input  logic            sdr_free_en,
    input  logic [NPCI-1:0] pci_en,
    input  logic            pci_free_en,
    output logic [NCPU-1:0] cpu_clk_o,
    output logic            cpu_free_o,
    output logic [NSDR-1:0] sdr_clk_o,
    output logic            sdr_free_o,
    output logic [NPCI-1:0] pci_clk_o,
    output logic            pci_free_o
);
    logic cpu_phase_nxt, cpu_rise, cpu_fall;
    logic pci_phase_nxt, pci_rise, pci_fall;
    logic cpu_gate, pci_gate;

    // CPU-rate clock from the reference.
    ckg_divider #(.HALF(CPU_HALF)) u_cpu_div (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .phase_nxt(cpu_phase_nxt), .rise_tick(cpu_rise), .fall_tick(cpu_fall)
    );

    // PCI-rate clock, stepped on CPU rising ticks.
    ckg_divider #(.HALF(PCI_HALF)) u_pci_div (
        .clk(clk), .rst_n(rst_n), .step(cpu_rise),
        .phase_nxt(pci_phase_nxt), .rise_tick(pci_rise), .fall_tick(pci_fall)
    );

    ckg_stop_ctrl #(.MIN_RUN(CPU_MIN_RUN)) u_cpu_stop (
        .clk(clk), .rst_n(rst_n), .stop_n(cpu_stop_n),
        .rise_tick(cpu_rise), .fall_tick(cpu_fall), .gate(cpu_gate)
    );

    ckg_stop_ctrl #(.MIN_RUN(PCI_MIN_RUN)) u_pci_stop (
        .clk(clk), .rst_n(rst_n), .stop_n(pci_stop_n),
        .rise_tick(pci_rise), .fall_tick(pci_fall), .gate(pci_gate)
    );

    ckg_out_bank #(.N(NCPU)) u_cpu_bank (
        .clk(clk), .rst_n(rst_n), .phase_nxt(cpu_phase_nxt), .fall_tick(cpu_fall),
        .gate(cpu_gate), .en(cpu_en), .clk_o(cpu_clk_o)
    );

    ckg_out_bank #(.N(NSDR)) u_sdr_bank (
        .clk(clk), .rst_n(rst_n), .phase_nxt(cpu_phase_nxt), .fall_tick(cpu_fall),
        .gate(cpu_gate), .en(sdr_en), .clk_o(sdr_clk_o)
    );

    ckg_out_bank #(.N(1)) u_cpu_free (
        .clk(clk), .rst_n(rst_n), .phase_nxt(cpu_phase_nxt), .fall_tick(cpu_fall),
        .gate(1'b1), .en(cpu_free_en), .clk_o(cpu_free_o)
    );

    ckg_out_bank #(.N(1)) u_sdr_free (
        .clk(clk), .rst_n(rst_n), .phase_nxt(cpu_phase_nxt), .fall_tick(cpu_fall),
        .gate(1'b1), .en(sdr_free_en), .clk_o(sdr_free_o)
    );

    ckg_out_bank #(.N(NPCI)) u_pci_bank (
        .clk(clk), .rst_n(rst_n), .phase_nxt(pci_phase_nxt), .fall_tick(pci_fall),
        .gate(pci_gate), .en(pci_en), .clk_o(pci_clk_o)
    );

    ckg_out_bank #(.N(1)) u_pci_free (
        .clk(clk), .rst_n(rst_n), .phase_nxt(pci_phase_nxt), .fall_tick(pci_fall),
        .gate(1'b1), .en(pci_free_en), .clk_o(pci_free_o)
    );
endmodule

// File: rtl/ckg_checker.sv
`timescale 1ns/1ps
// Property checker for ckstop_gate_top, attached with bind.
// It watches the family phases, the gates and the outputs. It keeps its own
// pulse counters to check the minimum run windows.
module ckg_checker #(
    parameter int NCPU        = 3,
    parameter int NSDR        = 8,
    parameter int NPCI        = 6,
    parameter int CPU_MIN_RUN = 100,
    parameter int PCI_MIN_RUN = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_ph,
    input logic            pci_ph,
    input logic            cpu_gate,
    input logic            pci_gate,
    input logic            cpu_rise,
    input logic            pci_rise,
    input logic [NCPU-1:0] cpu_o,
    input logic [NSDR-1:0] sdr_o,
    input logic [NPCI-1:0] pci_o
);
    localparam int CW = ckg_pkg::cnt_width(CPU_MIN_RUN + 1);
    localparam int PW = ckg_pkg::cnt_width(PCI_MIN_RUN + 1);

    logic [CW-1:0] cpu_pulses;
    logic [PW-1:0] pci_pulses;

    // Count pulses delivered while each gate is open (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_pulses <= '0;
            pci_pulses <= '0;
        end else begin
            if (!cpu_gate) cpu_pulses <= '0;
            else if (cpu_rise && int'(cpu_pulses) < CPU_MIN_RUN) cpu_pulses <= cpu_pulses + 1'b1;
            if (!pci_gate) pci_pulses <= '0;
            else if (pci_rise && int'(pci_pulses) < PCI_MIN_RUN) pci_pulses <= pci_pulses + 1'b1;
        end
    end

    a_r8_cpu_low_when_phase_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ph |-> (cpu_o == '0 && sdr_o == '0));
    a_r8_pci_low_when_phase_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_ph |-> (pci_o == '0));
    a_r8_cpu_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_o & ~$past(cpu_o)) != '0 || (sdr_o & ~$past(sdr_o)) != '0) |-> $rose(cpu_ph));
    a_r8_cpu_fall_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cpu_o & $past(cpu_o)) != '0 || (~sdr_o & $past(sdr_o)) != '0) |-> $fell(cpu_ph));
    a_r8_pci_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((pci_o & ~$past(pci_o)) != '0) |-> $rose(pci_ph));
    a_r8_pci_fall_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pci_o & $past(pci_o)) != '0) |-> $fell(pci_ph));
    a_r8_cpu_gate_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_gate) |-> !cpu_ph);
    a_r8_pci_gate_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pci_gate) |-> !pci_ph);
    a_r4_cpu_min_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_gate) |-> int'($past(cpu_pulses)) >= CPU_MIN_RUN);
    a_r7_pci_min_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_gate) |-> int'($past(pci_pulses)) >= PCI_MIN_RUN);
    a_r11_pci_rise_on_cpu_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_ph) |-> $rose(cpu_ph));
endmodule

bind ckstop_gate_top ckg_checker #(
    .NCPU(NCPU), .NSDR(NSDR), .NPCI(NPCI),
    .CPU_MIN_RUN(CPU_MIN_RUN), .PCI_MIN_RUN(PCI_MIN_RUN)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_ph(u_cpu_div.phase), .pci_ph(u_pci_div.phase),
    .cpu_gate(cpu_gate), .pci_gate(pci_gate),
    .cpu_rise(cpu_rise), .pci_rise(pci_rise),
    .cpu_o(cpu_clk_o), .sdr_o(sdr_clk_o), .pci_o(pci_clk_o)
);

// File: tb/tb_ckstop_gate_top.sv
`timescale 1ns/1ps
module tb_ckstop_gate_top;
    localparam int NCPU = 3, NSDR = 8, NPCI = 6;
    localparam int CPU_HALF = 2, PCI_HALF = 2, CPU_MIN = 100, PCI_MIN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic [NCPU-1:0] cpu_en = '1;
    logic [NSDR-1:0] sdr_en = '1;
    logic [NPCI-1:0] pci_en = '1;
    logic cpu_free_en = 1'b1, sdr_free_en = 1'b1, pci_free_en = 1'b1;
    logic [NCPU-1:0] cpu_clk_o;
    logic [NSDR-1:0] sdr_clk_o;
    logic [NPCI-1:0] pci_clk_o;
    logic cpu_free_o, sdr_free_o, pci_free_o;

    always #2.5 clk = ~clk;

    ckstop_gate_top #(.NCPU(NCPU), .NSDR(NSDR), .NPCI(NPCI), .CPU_HALF(CPU_HALF),
        .PCI_HALF(PCI_HALF), .CPU_MIN_RUN(CPU_MIN), .PCI_MIN_RUN(PCI_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_en(cpu_en), .cpu_free_en(cpu_free_en), .sdr_en(sdr_en), .sdr_free_en(sdr_free_en),
        .pci_en(pci_en), .pci_free_en(pci_free_en), .cpu_clk_o(cpu_clk_o), .cpu_free_o(cpu_free_o),
        .sdr_clk_o(sdr_clk_o), .sdr_free_o(sdr_free_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o));

    int total = 0, bad = 0;
    bit mon_on = 0, done = 0;

    // Edge model per family (0 = CPU, 1 = PCI).
    bit m_on[2], m_h1[2], m_h2[2];
    int m_run[2], m_skip[2];
    bit prev_cf = 0, prev_pf = 0, pci_seen = 0;
    int cpu_since_pci = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected gate state at a family rising edge, from the latency and run rules.
    function automatic bit exp_gate(input bit on, input bit h2, input int run, input int minr);
        return on ? !(!h2 && run >= minr) : h2;
    endfunction

    task automatic grp_edge(input int g, input bit req, input logic [15:0] act,
                            input logic [15:0] en, input int minr,
                            input string t_run, input string t_stop,
                            input string t_start, input string t_pend);
        bit e;
        string tag;
        e = exp_gate(m_on[g], m_h2[g], m_run[g], minr);
        if (m_on[g] && e && !m_h2[g]) tag = t_pend;
        else if (m_on[g] && !e)      tag = t_stop;
        else if (!m_on[g] && e)      tag = t_start;
        else                         tag = t_run;
        if (e) m_run[g] = (m_on[g] ? m_run[g] : 0) + 1;
        else   m_run[g] = 0;
        if (m_run[g] > minr) m_run[g] = minr;
        m_on[g] = e;
        if (m_skip[g] > 0) m_skip[g]--;
        else chk(act == (e ? en : 16'h0), tag, "gated pulses", act, e ? en : 16'h0);
        m_h2[g] = m_h1[g];
        m_h1[g] = req;
    endtask

    task automatic model_init(input bit settled);
        for (int g = 0; g < 2; g++) begin
            m_on[g] = 1; m_h1[g] = 1; m_h2[g] = 1; m_skip[g] = 0;
            m_run[g] = settled ? (g == 0 ? CPU_MIN : PCI_MIN) : 0;
        end
        prev_cf = cpu_free_o; prev_pf = pci_free_o;
        pci_seen = 0; cpu_since_pci = 0;
    endtask

    // Monitor: sample 1 ns after each rising reference edge.
    always @(posedge clk) begin
        bit cpu_now;
        #1;
        cpu_now = 0;
        if (mon_on) begin
            if (cpu_free_o && !prev_cf) begin
                cpu_now = 1;
                grp_edge(0, cpu_stop_n, {5'b0, sdr_clk_o, cpu_clk_o}, {5'b0, sdr_en, cpu_en},
                         CPU_MIN, "R1", "R2", "R3", "R4");
                cpu_since_pci++;
            end
            if (pci_free_o && !prev_pf) begin
                grp_edge(1, pci_stop_n, {10'b0, pci_clk_o}, {10'b0, pci_en},
                         PCI_MIN, "R5", "R6", "R6", "R7");
                if (pci_seen)
                    chk(cpu_now && cpu_since_pci == 2 * PCI_HALF, "R11", "cpu edges per pci period",
                        cpu_since_pci, 2 * PCI_HALF);
                pci_seen = 1;
                cpu_since_pci = 0;
            end
            // R8: gated outputs never high outside the family high phase.
            if (((cpu_clk_o & ~{NCPU{cpu_free_o}}) != '0) || ((sdr_clk_o & ~{NSDR{cpu_free_o}}) != '0)
                || ((pci_clk_o & ~{NPCI{pci_free_o}}) != '0))
                chk(0, "R8", "gated high outside phase", {cpu_clk_o, sdr_clk_o, pci_clk_o}, 0);
        end
        prev_cf = cpu_free_o;
        prev_pf = pci_free_o;
    end

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int viol, rises;
        logic [NCPU-1:0] pc;
        logic [NSDR-1:0] ps;
        logic [NPCI-1:0] pp;
        void'($urandom(32'd20240611));
        // R10: outputs low while in reset.
        repeat (10) @(negedge clk);
        chk({cpu_clk_o, sdr_clk_o, pci_clk_o, cpu_free_o, sdr_free_o, pci_free_o} == '0,
            "R10", "outputs in reset", {cpu_clk_o, sdr_clk_o, pci_clk_o}, 0);
        rst_n = 1'b1;
        model_init(0);
        mon_on = 1;
        repeat (400) @(negedge clk);

        // R9: masked outputs stay low, free-running ones included.
        mon_on = 0;
        cpu_en = 3'b010; sdr_en = 8'h81; pci_en = 6'b000001;
        cpu_free_en = 0; sdr_free_en = 0; pci_free_en = 0;
        repeat (40) @(negedge clk);
        viol = 0; rises = 0;
        pc = cpu_clk_o; ps = sdr_clk_o; pp = pci_clk_o;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if ((cpu_clk_o & ~cpu_en) != '0 || (sdr_clk_o & ~sdr_en) != '0 ||
                (pci_clk_o & ~pci_en) != '0 || cpu_free_o || sdr_free_o || pci_free_o) viol++;
            if (cpu_clk_o[1] && !pc[1]) rises++;
            pc = cpu_clk_o; ps = sdr_clk_o; pp = pci_clk_o;
        end
        chk(viol == 0, "R9", "masked outputs switching", viol, 0);
        chk(rises == 160 / (2 * CPU_HALF), "R9", "enabled cpu bit pulses", rises, 160 / (2 * CPU_HALF));
        cpu_en = '1; sdr_en = '1; pci_en = '1;
        cpu_free_en = 1; sdr_free_en = 1; pci_free_en = 1;
        repeat (60) @(negedge clk);
        model_init(1);
        mon_on = 1;

        // Directed: CPU stop after run window, then restart (R2, R3).
        cpu_stop_n = 0; repeat (60) @(negedge clk);
        cpu_stop_n = 1; repeat (30) @(negedge clk);
        // Directed: stop inside run window stays pending (R4), PCI the same (R7).
        cpu_stop_n = 0; pci_stop_n = 0; repeat (700) @(negedge clk);
        cpu_stop_n = 1; pci_stop_n = 1; repeat (20) @(negedge clk);
        pci_stop_n = 0; repeat (10) @(negedge clk);

        // Random mix of stop toggles and mask changes.
        for (int it = 0; it < 250; it++) begin
            repeat ($urandom_range(1, 300)) @(negedge clk);
            case ($urandom % 8)
                0, 1, 2: cpu_stop_n = ~cpu_stop_n;
                3, 4, 5: pci_stop_n = ~pci_stop_n;
                6: begin
                    cpu_en = NCPU'($urandom); sdr_en = NSDR'($urandom); m_skip[0] = 2;
                end
                default: begin
                    pci_en = NPCI'($urandom); m_skip[1] = 2;
                end
            endcase
        end
        cpu_stop_n = 1; pci_stop_n = 1;
        repeat (200) @(negedge clk);
        chk(m_on[0] && m_on[1], "R3", "both families running at end", {m_on[0], m_on[1]}, 2'b11);
        done = 1;
        summary();
        $finish;
    end
endmodule